// File: doc/BRIEF.md
# Reloading Down-Counter Timer Unit

This block is a multi-channel periodic timer. Every channel owns a down counter that steps by one on a tick drawn from a shared free-running clock divider, a reload value, and a control word. The control word picks one of four divide ratios, holds an interrupt enable, and holds a sticky flag. When a channel's counter is stepped while it is zero, it takes the reload value instead of wrapping and raises its flag. The flag drives that channel's interrupt line only while the enable is set.

Software reaches the unit over a plain synchronous register port. A write is taken on the rising clock edge while `wr_en` is high. Read data is combinational from the address. Address 0 holds the run register, where bit c starts or stops channel c. Channel c uses word addresses 4(c+1)+0 for control, 4(c+1)+1 for reload and 4(c+1)+2 for the counter.

Top module: `tmr_unit`

## Requirements
- R1: With the default three channels, each channel has its own control, reload and counter registers at addresses 4(c+1)+0, +1 and +2. A write to one channel's register leaves every other channel's registers unchanged.
- R2: After reset, every control word reads 0, every reload and counter reads 0xFFFFFFFF, the run register reads 0 and every irq bit is 0.
- R3: A running channel steps its counter down by exactly one per tick. Control bits 2:0 select the tick rate: code 0 gives clk/4, code 1 gives clk/16, code 2 gives clk/64 and code 3 gives clk/256. Over any 5×ratio consecutive cycles, the counter therefore drops by exactly 5.
- R4: A tick that arrives while the counter is 0 loads the reload value into the counter and sets the flag (control bit 8) at the same clock edge. Counting then continues down from the reload value.
- R5: While control bits 2:0 hold one of the codes 4 to 7, the channel's counter does not change, even when the channel is running.
- R6: irq[c] is 1 exactly when control bit 8 (the flag) and control bit 5 (the interrupt enable) of channel c are both 1.
- R7: A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag as it was. Outside these writes, the flag stays set until it is cleared.
- R8: Control bits other than 8, 5 and 2:0 always read 0, and writes to them have no effect. For example, writing 0x3D reads back as 0x25.
- R9: A channel whose run bit is 0 holds its counter value.
- R10: A write to a counter address loads the written value into that counter, and the counter address reads back its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed register |
| irq | output | 3 | Per-channel interrupt request |

## Verification
The bench builds the unit with its default parameters: three 32-bit channels and four divide ratios. At these values every ratio, up to clk/256, can be measured directly as an exact drop over a 5×ratio window. Preloading small counter values makes underflow, reload and the continued count after reload reachable within a few dozen cycles. Three channels are enough to show that one running channel leaves a stopped neighbour untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int PSC_W    = 3;
    localparam int FLAG_BIT = 8;
    localparam int UIE_BIT  = 5;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_RLD   = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ctrl;
        logic rld;
        logic count;
    } ch_wr_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int NUM_RATIOS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_RATIOS-1:0] ticks
);
    localparam int DIV_W = 2 * NUM_RATIOS;

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_tick
        assign ticks[k] = &div_q[2*k+1:0];
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int NUM_RATIOS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [NUM_RATIOS-1:0] ticks,
    input  ch_wr_t                wr,
    input  logic [CNT_W-1:0]      wdata,
    output logic [CNT_W-1:0]      ctrl_rd,
    output logic [CNT_W-1:0]      rld_o,
    output logic [CNT_W-1:0]      cnt_o,
    output logic [PSC_W-1:0]      psc_o,
    output logic                  flag_o,
    output logic                  uie_o,
    output logic                  irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic [PSC_W-1:0] psc;
        logic             uie;
        logic             flag;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      tick_sel;
    logic      step;
    logic      underflow;

    always_comb begin
        tick_sel = 1'b0;
        for (int k = 0; k < NUM_RATIOS; k++) begin
            if (int'(st_q.psc) == k) tick_sel = ticks[k];
        end
        step      = run && tick_sel;
        underflow = step && (st_q.cnt == '0);

        st_d = st_q;
        if (wr.ctrl) begin
            st_d.psc  = wdata[PSC_W-1:0];
            st_d.uie  = wdata[UIE_BIT];
            st_d.flag = st_q.flag & wdata[FLAG_BIT];
        end
        if (underflow) st_d.flag = 1'b1;
        if (wr.rld) st_d.rld = wdata;
        if (wr.count)      st_d.cnt = wdata;
        else if (underflow) st_d.cnt = st_q.rld;
        else if (step)      st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.rld  <= '1;
            st_q.psc  <= '0;
            st_q.uie  <= 1'b0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_rd              = '0;
        ctrl_rd[FLAG_BIT]    = st_q.flag;
        ctrl_rd[UIE_BIT]     = st_q.uie;
        ctrl_rd[PSC_W-1:0]   = st_q.psc;
    end

    assign rld_o  = st_q.rld;
    assign cnt_o  = st_q.cnt;
    assign psc_o  = st_q.psc;
    assign flag_o = st_q.flag;
    assign uie_o  = st_q.uie;
    assign irq    = st_q.flag & st_q.uie;
endmodule

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0]             run_q,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  ctrl_rd,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rld_rd,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_rd,
    output logic                          run_we,
    output ch_wr_t [NUM_CH-1:0]           ch_wr,
    output logic [CNT_W-1:0]              rd_data
);
    localparam int SLOT_W = ADDR_W - 2;

    logic [SLOT_W-1:0] slot;
    reg_sel_e          sel;

    always_comb begin
        slot    = addr[ADDR_W-1:2];
        sel     = reg_sel_e'(addr[1:0]);
        run_we  = wr_en && (slot == '0) && (sel == SEL_CTRL);
        rd_data = '0;
        if (slot == '0 && sel == SEL_CTRL) rd_data[NUM_CH-1:0] = run_q;
        for (int c = 0; c < NUM_CH; c++) begin
            ch_wr[c] = '0;
            if (int'(slot) == c + 1) begin
                ch_wr[c].ctrl  = wr_en && (sel == SEL_CTRL);
                ch_wr[c].rld   = wr_en && (sel == SEL_RLD);
                ch_wr[c].count = wr_en && (sel == SEL_COUNT);
                case (sel)
                    SEL_CTRL:  rd_data = ctrl_rd[c];
                    SEL_RLD:   rd_data = rld_rd[c];
                    SEL_COUNT: rd_data = cnt_rd[c];
                    default:   rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH     = 3,
    parameter int CNT_W      = 32,
    parameter int NUM_RATIOS = 4,
    parameter int ADDR_W     = $clog2(4 * (NUM_CH + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_RATIOS-1:0]          ticks;
    logic [NUM_CH-1:0]              run_d, run_q;
    logic                           run_we;
    ch_wr_t [NUM_CH-1:0]            ch_wr;
    logic [NUM_CH-1:0][CNT_W-1:0]   ctrl_arr, rld_arr, cnt_arr;
    logic [NUM_CH-1:0][PSC_W-1:0]   psc_arr;
    logic [NUM_CH-1:0]              flag_vec, uie_vec;

    tmr_prescaler #(.NUM_RATIOS(NUM_RATIOS)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .ticks (ticks)
    );

    tmr_bus_dec #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .run_q   (run_q),
        .ctrl_rd (ctrl_arr),
        .rld_rd  (rld_arr),
        .cnt_rd  (cnt_arr),
        .run_we  (run_we),
        .ch_wr   (ch_wr),
        .rd_data (rd_data)
    );

    always_comb begin
        run_d = run_q;
        if (run_we) run_d = wr_data[NUM_CH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W), .NUM_RATIOS(NUM_RATIOS)) i_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_q[c]),
            .ticks   (ticks),
            .wr      (ch_wr[c]),
            .wdata   (wr_data),
            .ctrl_rd (ctrl_arr[c]),
            .rld_o   (rld_arr[c]),
            .cnt_o   (cnt_arr[c]),
            .psc_o   (psc_arr[c]),
            .flag_o  (flag_vec[c]),
            .uie_o   (uie_vec[c]),
            .irq     (irq[c])
        );
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [NUM_CH-1:0]            irq,
    input logic [NUM_CH-1:0]            run_q,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_arr,
    input logic [NUM_CH-1:0][CNT_W-1:0] rld_arr,
    input logic [NUM_CH-1:0][2:0]       psc_arr,
    input logic [NUM_CH-1:0]            flag_vec,
    input logic [NUM_CH-1:0]            uie_vec
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic wr_cnt, wr_ctl;
        assign wr_cnt = wr_en && (addr == ADDR_W'(4 * (c + 1) + 2));
        assign wr_ctl = wr_en && (addr == ADDR_W'(4 * (c + 1)));

        AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[c] && !wr_cnt) |=> $stable(cnt_arr[c])); // R9
        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[c] && !wr_cnt && cnt_arr[c] != '0) |=>
            (cnt_arr[c] == $past(cnt_arr[c]) || cnt_arr[c] == $past(cnt_arr[c]) - 1'b1)); // R3
        AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[c] && !wr_cnt && cnt_arr[c] == '0) |=>
            (cnt_arr[c] == '0 || (cnt_arr[c] == $past(rld_arr[c]) && flag_vec[c]))); // R4
        AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (psc_arr[c][2] && !wr_cnt) |=> $stable(cnt_arr[c])); // R5
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_vec[c] && !wr_ctl) |=> flag_vec[c]); // R7
        AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> (flag_vec[c] && uie_vec[c])); // R6
    end
endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .irq      (irq),
    .run_q    (run_q),
    .cnt_arr  (cnt_arr),
    .rld_arr  (rld_arr),
    .psc_arr  (psc_arr),
    .flag_vec (flag_vec),
    .uie_vec  (uie_vec)
);

// File: tb/test_tmr_unit.sv
module test_tmr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_unit i_tmr_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [3:0] a_ctl(int c); return 4'(4 * (c + 1));     endfunction
    function automatic logic [3:0] a_rld(int c); return 4'(4 * (c + 1) + 1); endfunction
    function automatic logic [3:0] a_cnt(int c); return 4'(4 * (c + 1) + 2); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v); check("R2 run", v, 32'h0);
        for (int c = 0; c < 3; c++) begin
            rd(a_ctl(c), v); check("R2 ctrl", v, 32'h0);
            rd(a_rld(c), v); check("R2 reload", v, 32'hFFFF_FFFF);
            rd(a_cnt(c), v); check("R2 count", v, 32'hFFFF_FFFF);
        end
        check("R2 irq", {29'd0, irq}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(a_rld(0), 32'h1111_0000);
        wr(a_rld(2), 32'h2222_0000);
        wr(a_cnt(1), 32'h0000_ABCD);
        rd(a_rld(0), v); check("R1 ch0 reload", v, 32'h1111_0000);
        rd(a_rld(2), v); check("R1 ch2 reload", v, 32'h2222_0000);
        rd(a_rld(1), v); check("R1 ch1 reload untouched", v, 32'hFFFF_FFFF);
        rd(a_cnt(1), v); check("R10 count write", v, 32'h0000_ABCD);
        rd(a_cnt(0), v); check("R1 ch0 count untouched", v, 32'hFFFF_FFFF);
        wr(a_ctl(1), 32'hFFFF_FE3D);
        rd(a_ctl(1), v); check("R8 reserved bits", v, 32'h0000_0025);
        wr(a_ctl(1), 32'h0);
    endtask

    task automatic t_ratio(int code, int ratio);
        logic [31:0] v0, v1;
        wr(4'd0, 32'h0);
        wr(a_ctl(0), 32'(code));
        wr(a_cnt(0), 32'd1000);
        wr(4'd0, 32'h1);
        @(negedge clk); addr = a_cnt(0);
        #1 v0 = rd_data;
        repeat (5 * ratio) @(negedge clk);
        #1 v1 = rd_data;
        check($sformatf("R3 code %0d drop", code), v0 - v1, 32'd5);
        wr(4'd0, 32'h0);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        bit seen = 0;
        wr(4'd0, 32'h0);
        wr(a_ctl(0), 32'h0);
        wr(a_rld(0), 32'd7);
        wr(a_cnt(0), 32'd2);
        wr(4'd0, 32'h1);
        @(negedge clk); addr = a_ctl(0);
        for (int i = 0; i < 200 && !seen; i++) begin
            #1;
            if (rd_data[8]) seen = 1;
            else @(negedge clk);
        end
        check("R4 flag set", {31'd0, seen}, 32'h1);
        addr = a_cnt(0);
        #1 check("R4 reload value", rd_data, 32'd7);
        check("R6 irq off when disabled", {31'd0, irq[0]}, 32'h0);
        repeat (4) @(negedge clk);
        #1 check("R4 count continues from reload", rd_data, 32'd6);
        wr(4'd0, 32'h0);
        wr(a_ctl(0), 32'h120);
        rd(a_ctl(0), v); check("R7 write 1 keeps flag", v, 32'h120);
        check("R6 irq on", {31'd0, irq[0]}, 32'h1);
        wr(a_ctl(0), 32'h020);
        rd(a_ctl(0), v); check("R7 write 0 clears flag", v, 32'h020);
        check("R6 irq off after clear", {31'd0, irq[0]}, 32'h0);
        wr(a_ctl(0), 32'h0);
    endtask

    task automatic t_reserved_code();
        logic [31:0] v;
        wr(a_ctl(2), 32'h0000_0025);
        wr(a_cnt(2), 32'd50);
        wr(4'd0, 32'h4);
        repeat (600) @(negedge clk);
        rd(a_cnt(2), v); check("R5 reserved code holds", v, 32'd50);
        rd(a_ctl(2), v); check("R5 no flag", v, 32'h25);
        wr(4'd0, 32'h0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(a_ctl(0), 32'h0);
        wr(a_ctl(1), 32'h0);
        wr(a_cnt(0), 32'd500);
        wr(a_cnt(1), 32'd20);
        wr(4'd0, 32'h1);
        repeat (100) @(negedge clk);
        rd(a_cnt(1), v); check("R9 stopped channel holds", v, 32'd20);
        rd(4'd0, v); check("R9 run reg", v, 32'h1);
        wr(4'd0, 32'h0);
        rd(a_cnt(0), v);
        repeat (50) @(negedge clk);
        begin
            logic [31:0] w;
            rd(a_cnt(0), w); check("R9 stopped ch0 holds", w, v);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_ratio(0, 4);
        t_ratio(1, 16);
        t_ratio(2, 64);
        t_ratio(3, 256);
        t_underflow();
        t_reserved_code();
        t_stop();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule